// File: doc/BRIEF.md
# Codec register access controller

This block is the host-facing register bank that a CPU uses to reach the internal registers of an external audio codec. It sits on a simple word-addressed bus slave and holds four words: a control word, the codec register address, the outgoing data word and the incoming data word. The serial link that carries the transaction to the codec is outside this block. It only sees the event pulses this block raises.

Software loads the codec address and, for a write, the outgoing data. It then writes the control word with the request bit set. The direction bit in that same write decides which of two event outputs pulses for one cycle. The request bit is never stored, so the control word reads back with it at zero. Accesses to word indices past the four mapped ones read as zero and change nothing. They also raise a one-cycle error flag.

Top module: `codec_regbank`

## Requirements
- R1: The word index is the bus byte address shifted right by two, so address bits [1:0] are ignored. Index 0 is control, 1 is codec address, 2 is outgoing data and 3 is incoming data.
- R2: A write to index 1, 2 or 3 stores the full data word unchanged, and a later read of that index returns it.
- R3: A control write with bit 0 (request) = 1 and bit 1 (direction) = 1 makes `cr_req_evt` high for exactly the one cycle after the write edge.
- R4: A control write with bit 0 = 1 and bit 1 = 0 makes `cr_reply_evt` high for exactly the one cycle after the write edge.
- R5: The stored control word always has bit 0 cleared. All its other bits read back as written.
- R6: A control write with bit 0 = 0 updates the stored control bits and produces no event pulse.
- R7: An access to an index of 4 or above reads as zero and changes no register. It raises `bus_err` for exactly the one cycle after the access edge.
- R8: Reset clears all four registers to zero and holds the event and error outputs low.
- R9: `cr_req_evt` and `cr_reply_evt` are never high in the same cycle.
- R10: `bus_rdata` is zero in every cycle that is not a read (`bus_sel` low or `bus_we` high). During a read it shows the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read |
| bus_err | output | 1 | One-cycle flag after an access to an unmapped index |
| cr_req_evt | output | 1 | One-cycle pulse: codec write transaction requested |
| cr_reply_evt | output | 1 | One-cycle pulse: codec read transaction requested |

## Verification
The bench builds the block with DATA_W = 32 and ADDR_W = 6. This gives sixteen word indices, so twelve of them are unmapped, and both the first unmapped index (4) and the last one (15) can be reached in a short walk. The full 32-bit width lets all-ones and mixed patterns show that nothing is masked apart from control bit 0. Back-to-back control writes with opposite directions check that each pulse lasts one cycle and that the two event outputs keep apart.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;
  // word map (index = byte address >> 2)
  localparam int NUM_REGS  = 4;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_CADDR = 1;
  localparam int IDX_DOUT  = 2;
  localparam int IDX_DIN   = 3;
  localparam int NUM_DATA  = NUM_REGS - 1;
  // control word bits
  localparam int BIT_RQ  = 0;
  localparam int BIT_DIR = 1;
endpackage

// File: rtl/codec_regbank_decode.sv
module codec_regbank_decode
  import codec_regbank_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  output logic [NUM_REGS-1:0] hit,
  output logic             unmapped
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = sel && (idx == IDX_W'(i));
  end

  assign unmapped = sel && !(|hit);

  always_comb begin
    a_r1_onehot_hit: assert ($onehot0(hit));
  end
endmodule

// File: rtl/codec_regbank_ctrl.sv
module codec_regbank_ctrl
  import codec_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              req_evt,
  output logic              reply_evt
);
  logic [DATA_W-1:0] ctrl_d;
  logic              req_d;
  logic              reply_d;

  // next state
  always_comb begin
    ctrl_d  = wdata;
    ctrl_d[BIT_RQ] = 1'b0;
    req_d   = 1'b0;
    reply_d = 1'b0;
    if (wr_en && wdata[BIT_RQ]) begin
      req_d   = wdata[BIT_DIR];
      reply_d = !wdata[BIT_DIR];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      req_evt   <= 1'b0;
      reply_evt <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= ctrl_d;
      req_evt   <= req_d;
      reply_evt <= reply_d;
    end
  end

  a_r3_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_evt |-> $past(wr_en && wdata[BIT_RQ] && wdata[BIT_DIR]));
  a_r4_reply_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reply_evt |-> $past(wr_en && wdata[BIT_RQ] && !wdata[BIT_DIR]));
  a_r5_rq_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q[BIT_RQ] == 1'b0) &&
              (ctrl_q[DATA_W-1:1] == $past(wdata[DATA_W-1:1])));
  a_r6_no_pulse_without_rq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[BIT_RQ]) |=> !req_evt && !reply_evt);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_evt && reply_evt));
endmodule

// File: rtl/codec_regbank_store.sv
module codec_regbank_store
  import codec_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_DATA-1:0]              wr_en,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_DATA-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
    logic [DATA_W-1:0] d;

    always_comb d = wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= '0;
      else if (wr_en[i]) q[i] <= d;
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[i] |=> $stable(q[i]));
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> q[i] == $past(wdata));
  end
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
  import codec_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              cr_req_evt,
  output logic              cr_reply_evt
);
  localparam int IDX_W = ADDR_W - 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // address decode
  logic [NUM_REGS-1:0] hit;
  logic                unmapped;
  logic                unused_byte_ofs;
  assign unused_byte_ofs = ^bus_addr[1:0];

  codec_regbank_decode #(.IDX_W(IDX_W)) u_decode (
    .sel      (bus_sel),
    .idx      (bus_addr[ADDR_W-1:2]),
    .hit      (hit),
    .unmapped (unmapped)
  );

  // control word and event pulses
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_wr;
  assign ctrl_wr = bus_we && hit[IDX_CTRL];

  codec_regbank_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (ctrl_wr),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .req_evt   (cr_req_evt),
    .reply_evt (cr_reply_evt)
  );

  // address / data words
  logic [NUM_DATA-1:0]             data_wr;
  logic [NUM_DATA-1:0][DATA_W-1:0] data_q;
  assign data_wr = {NUM_DATA{bus_we}} & hit[NUM_REGS-1:1];

  codec_regbank_store #(.DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (data_wr),
    .wdata (bus_wdata),
    .q     (data_q)
  );

  // read path (same cycle)
  logic [NUM_REGS-1:0][DATA_W-1:0] words;
  assign words = {data_q, ctrl_q};

  always_comb begin
    bus_rdata = '0;
    if (!bus_we) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (hit[i]) bus_rdata = bus_rdata | words[i];
      end
    end
  end

  // unmapped access flag
  logic err_d;
  assign err_d = unmapped;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_err <= 1'b0;
    else             bus_err <= err_d;
  end

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_err |-> $past(bus_sel && (bus_addr[ADDR_W-1:2] >= IDX_W'(NUM_REGS - 1)) &&
                      (bus_addr[ADDR_W-1:2] != IDX_W'(NUM_REGS - 1))));
  a_r7_unmapped_no_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unmapped |=> $stable(ctrl_q) && $stable(data_q));
  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !cr_req_evt && !cr_reply_evt && !bus_err);
  always_comb begin
    if (!(bus_sel && !bus_we)) a_r10_idle_zero: assert (bus_rdata == '0);
  end
endmodule

// File: tb/codec_regbank_tb.sv
module codec_regbank_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int NVEC   = 19;
  localparam int VW     = 1 + ADDR_W + DATA_W + DATA_W + 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_err;
  logic              cr_req_evt;
  logic              cr_reply_evt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  codec_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .cr_req_evt   (cr_req_evt),
    .cr_reply_evt (cr_reply_evt)
  );

  // {we, addr, wdata, expected rdata (reads), req, reply, err}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 6'h04, 32'h0000_0055, 32'h0, 3'b000},  // R2 codec address
    {1'b0, 6'h04, 32'h0,         32'h0000_0055, 3'b000},
    {1'b1, 6'h08, 32'hDEAD_BEEF, 32'h0, 3'b000},  // R2 outgoing data
    {1'b0, 6'h0B, 32'h0,         32'hDEAD_BEEF, 3'b000},  // R1 low bits ignored
    {1'b1, 6'h0C, 32'hFFFF_FFFF, 32'h0, 3'b000},  // R2 incoming data
    {1'b0, 6'h0C, 32'h0,         32'hFFFF_FFFF, 3'b000},
    {1'b1, 6'h00, 32'h0000_0003, 32'h0, 3'b100},  // R3 write request
    {1'b0, 6'h00, 32'h0,         32'h0000_0002, 3'b000},  // R5
    {1'b1, 6'h00, 32'h0000_0001, 32'h0, 3'b010},  // R4 read request
    {1'b0, 6'h00, 32'h0,         32'h0000_0000, 3'b000},  // R5
    {1'b1, 6'h00, 32'hA5A5_A5A6, 32'h0, 3'b000},  // R6 no request
    {1'b0, 6'h01, 32'h0,         32'hA5A5_A5A6, 3'b000},  // R6 / R1
    {1'b1, 6'h10, 32'h0000_1234, 32'h0, 3'b001},  // R7 write index 4
    {1'b0, 6'h10, 32'h0,         32'h0,         3'b001},  // R7 read index 4
    {1'b0, 6'h3C, 32'h0,         32'h0,         3'b001},  // R7 read index 15
    {1'b0, 6'h04, 32'h0,         32'h0000_0055, 3'b000},  // R7 nothing changed
    {1'b1, 6'h00, 32'hFFFF_FFFF, 32'h0, 3'b100},  // R9 back to back
    {1'b1, 6'h00, 32'h0000_0001, 32'h0, 3'b010},  // R9
    {1'b0, 6'h00, 32'h0,         32'h0000_0000, 3'b000}
  };

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic drive(input logic we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] exp);
    drive(1'b0, a, '0);
    #1 check(tag, bus_rdata, exp);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    do_reset();

    // reset state
    check("R8 req low", {31'b0, cr_req_evt}, 32'h0);
    check("R8 reply low", {31'b0, cr_reply_evt}, 32'h0);
    check("R8 err low", {31'b0, bus_err}, 32'h0);
    for (int i = 0; i < 4; i++) read_chk("R8 word cleared", ADDR_W'(i * 4), 32'h0);
    #1 check("R10 rdata zero when idle", bus_rdata, 32'h0);

    // vector walk, one access per cycle
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      logic [DATA_W-1:0] exp_rd;
      logic [2:0] ev;
      v      = VEC[i];
      ev     = v[2:0];
      exp_rd = v[DATA_W+2:3];
      drive(v[VW-1], v[VW-2 -: ADDR_W], v[2*DATA_W+2 -: DATA_W]);
      #1;
      if (!v[VW-1]) check("R1/R2 read data", bus_rdata, exp_rd);
      else          check("R10 rdata zero on write", bus_rdata, 32'h0);
      @(negedge clk);
      check("R3 req pulse", {31'b0, cr_req_evt}, {31'b0, ev[2]});
      check("R4 reply pulse", {31'b0, cr_reply_evt}, {31'b0, ev[1]});
      check("R7 err pulse", {31'b0, bus_err}, {31'b0, ev[0]});
    end
    idle();

    // one-cycle width of each pulse
    drive(1'b1, 6'h00, 32'h0000_0003);
    @(negedge clk); idle();
    check("R3 pulse high", {31'b0, cr_req_evt}, 32'h1);
    @(negedge clk);
    check("R3 pulse one cycle", {31'b0, cr_req_evt}, 32'h0);
    drive(1'b1, 6'h00, 32'h0000_0001);
    @(negedge clk); idle();
    check("R4 pulse high", {31'b0, cr_reply_evt}, 32'h1);
    check("R9 req stays low", {31'b0, cr_req_evt}, 32'h0);
    @(negedge clk);
    check("R4 pulse one cycle", {31'b0, cr_reply_evt}, 32'h0);
    drive(1'b0, 6'h20, '0);
    @(negedge clk); idle();
    @(negedge clk);
    check("R7 err one cycle", {31'b0, bus_err}, 32'h0);

    // reset in the middle of use
    drive(1'b1, 6'h08, 32'h1357_9BDF);
    @(negedge clk);
    drive(1'b1, 6'h00, 32'hF0F0_F0F2);
    @(negedge clk); idle();
    read_chk("R2 loaded before reset", 6'h08, 32'h1357_9BDF);
    do_reset();
    read_chk("R8 control cleared", 6'h00, 32'h0);
    read_chk("R8 out data cleared", 6'h08, 32'h0);
    read_chk("R8 address cleared", 6'h04, 32'h0);
    read_chk("R8 in data cleared", 6'h0C, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule